// File: doc/BRIEF.md
# Scrambling Key Renewal Controller

This block owns the data scrambling key and nonce that a memory scrambler uses. Out of reset both are zero, and scrambling runs with these zero values. Software writes a renew command. The block then starts a request toward a key-derivation source that runs on a separate clock. It marks the memory busy so that accesses fail, and it asks the memory to wipe its contents. When the source acknowledges, the block loads the new key, nonce and seed-valid flag and sets the key-valid status.

The request and the acknowledge cross between the two clock domains as level signals, each through a two-flop synchronizer, in a four-phase handshake. The key and nonce are not synchronized. They are sampled straight off the source's bus when the synchronized acknowledge arrives, which relies on the source holding them stable for a long window. A sticky lock bit can shut off the renew command until reset. A four-bit escalation input zeroes the key material whenever it holds anything other than its off code.

Top module: `key_renewal_ctrl`

## Requirements
- R1: After reset, key_o and nonce_o are all zero; key_valid_o, seed_valid_o, busy_o, wipe_o and kd_req_o are 0; renew_en_o is 1.
- R2: A write with renew_we_i=1 and renew_wdata_i=1 is accepted when renew_en_o=1 and no request is in progress. On the next clk_i cycle busy_o is 1, wipe_o is 1 for exactly one cycle, and key_valid_o is 0.
- R3: kd_req_o rises in the clk_kd_i domain after an accepted renew. It stays 1 until a cycle in which kd_ack_i is 1, and it is 0 in the following clk_kd_i cycle.
- R4: When the synchronized acknowledge arrives, key_o and nonce_o take the values present on kd_key_i and kd_nonce_i, key_valid_o becomes 1 and busy_o falls in the same cycle.
- R5: seed_valid_o takes the value of kd_seed_valid_i sampled with the key.
- R6: busy_o stays 1 from acceptance until the key is loaded, and key_valid_o is 0 whenever busy_o is 1.
- R7: A renew write made while a request is in progress is ignored: there is no second wipe pulse, and a single acknowledge completes the request.
- R8: Writing lock_wdata_i=0 with lock_we_i=1 clears renew_en_o. A 1 written afterwards does not set it again before reset. While renew_en_o is 0, renew writes change neither busy_o, wipe_o, key_valid_o nor key_o.
- R9: Any escalate_i value other than 4'b0101 forces key_o and nonce_o to zero in the same cycle. key_valid_o is 0 from the next cycle on, and the key stays zero after escalation is withdrawn.
- R10: An acknowledge that arrives while escalation is active loads no key. key_o stays zero, key_valid_o stays 0 and busy_o still falls.
- R11: A renew write with renew_wdata_i=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Core active-low asynchronous reset |
| clk_kd_i | input | 1 | Key-derivation domain clock |
| rst_kd_ni | input | 1 | Key-derivation domain active-low asynchronous reset |
| renew_we_i | input | 1 | Write strobe for the renew command |
| renew_wdata_i | input | 1 | Renew command data bit |
| lock_we_i | input | 1 | Write strobe for the renew enable bit |
| lock_wdata_i | input | 1 | Renew enable data; 0 locks |
| renew_en_o | output | 1 | Renew command still enabled |
| key_valid_o | output | 1 | A fresh key has been loaded |
| seed_valid_o | output | 1 | Key was derived from provisioned seeds |
| escalate_i | input | 4 | Escalation code; 4'b0101 means off |
| kd_req_o | output | 1 | Key request to the derivation source (clk_kd_i domain) |
| kd_ack_i | input | 1 | One-cycle acknowledge (clk_kd_i domain) |
| kd_key_i | input | KeyW | Returned key |
| kd_nonce_i | input | NonceW | Returned nonce |
| kd_seed_valid_i | input | 1 | Returned seed-valid flag |
| key_o | output | KeyW | Key to the scrambler |
| nonce_o | output | NonceW | Nonce to the scrambler |
| wipe_o | output | 1 | One-cycle memory wipe request |
| busy_o | output | 1 | Request in progress; memory accesses must fail |

## Verification
The bench drives escalation and the loading of a returned key into the same core cycle. It raises escalate_i before the responder pulses its acknowledge and holds it until busy_o falls. It then checks that the key stays zero, that key-valid never rises and that the handshake still closes. A second overlap has a renew write land while a request is in flight: no further wipe pulse may appear, and one acknowledge must finish the exchange with the first key.

// File: rtl/key_renew_pkg.sv
package key_renew_pkg;
  localparam int unsigned EscW = 4;
  localparam logic [EscW-1:0] EscOff = 4'b0101;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_WAIT  = 2'd1,
    HS_DRAIN = 2'd2
  } hs_state_e;
endpackage

// File: rtl/kr_sync_2ff.sv
module kr_sync_2ff #(
  parameter int unsigned Width = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [Width-1:0] d_i,
  output logic [Width-1:0] q_o
);
  logic [Width-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/kr_handshake.sv
module kr_handshake
  import key_renew_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_kd_i,
  input  logic rst_kd_ni,
  input  logic start_i,
  output logic ack_evt_o,
  output logic busy_o,
  output logic pending_o,
  output logic kd_req_o,
  input  logic kd_ack_i
);
  hs_state_e state_q, state_d;
  logic req_lvl, req_kd, done_q, done_sync;

  assign req_lvl = (state_q == HS_WAIT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:  if (start_i) state_d = HS_WAIT;
      HS_WAIT:  if (done_sync) state_d = HS_DRAIN;
      HS_DRAIN: if (!done_sync) state_d = HS_IDLE;
      default:  state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_IDLE;
    else         state_q <= state_d;
  end

  kr_sync_2ff #(.Width(1)) i_req_sync (
    .clk_i (clk_kd_i),
    .rst_ni(rst_kd_ni),
    .d_i   (req_lvl),
    .q_o   (req_kd)
  );

  // done level returns to idle only once the request level has dropped
  always_ff @(posedge clk_kd_i or negedge rst_kd_ni) begin
    if (!rst_kd_ni)            done_q <= 1'b0;
    else if (!req_kd)          done_q <= 1'b0;
    else if (kd_ack_i)         done_q <= 1'b1;
  end

  kr_sync_2ff #(.Width(1)) i_done_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (done_q),
    .q_o   (done_sync)
  );

  assign kd_req_o  = req_kd & ~done_q;
  assign ack_evt_o = req_lvl & done_sync;
  assign busy_o    = req_lvl;
  assign pending_o = (state_q != HS_IDLE);

  // R3
  req_hold_chk: assert property (@(posedge clk_kd_i) disable iff (!rst_kd_ni)
    kd_req_o && !kd_ack_i |=> kd_req_o);
  // R3
  req_drop_chk: assert property (@(posedge clk_kd_i) disable iff (!rst_kd_ni)
    kd_req_o && kd_ack_i |=> !kd_req_o);
  // R7
  one_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_evt_o |=> !ack_evt_o);
endmodule

// File: rtl/kr_key_store.sv
module kr_key_store #(
  parameter int unsigned KeyW   = 128,
  parameter int unsigned NonceW = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              esc_i,
  input  logic              invalidate_i,
  input  logic              capture_i,
  input  logic [KeyW-1:0]   kd_key_i,
  input  logic [NonceW-1:0] kd_nonce_i,
  input  logic              kd_seed_valid_i,
  output logic [KeyW-1:0]   key_o,
  output logic [NonceW-1:0] nonce_o,
  output logic              key_valid_o,
  output logic              seed_valid_o
);
  logic [KeyW-1:0]   key_q;
  logic [NonceW-1:0] nonce_q;
  logic              valid_q, seed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      nonce_q <= '0;
      valid_q <= 1'b0;
      seed_q  <= 1'b0;
    end else if (esc_i) begin
      key_q   <= '0;
      nonce_q <= '0;
      valid_q <= 1'b0;
      if (capture_i) seed_q <= kd_seed_valid_i;
    end else if (capture_i) begin
      // kd bus is held stable by the source well past the synced ack
      key_q   <= kd_key_i;
      nonce_q <= kd_nonce_i;
      valid_q <= 1'b1;
      seed_q  <= kd_seed_valid_i;
    end else if (invalidate_i) begin
      valid_q <= 1'b0;
    end
  end

  assign key_o        = esc_i ? '0 : key_q;
  assign nonce_o      = esc_i ? '0 : nonce_q;
  assign key_valid_o  = valid_q;
  assign seed_valid_o = seed_q;

  // R9
  esc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_i |=> !key_valid_o && key_q == '0 && nonce_q == '0);
  // R4
  capture_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i && !esc_i |=> key_valid_o);
endmodule

// File: rtl/key_renewal_ctrl.sv
module key_renewal_ctrl
  import key_renew_pkg::*;
#(
  parameter int unsigned KeyW   = 128,
  parameter int unsigned NonceW = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_kd_i,
  input  logic              rst_kd_ni,
  input  logic              renew_we_i,
  input  logic              renew_wdata_i,
  input  logic              lock_we_i,
  input  logic              lock_wdata_i,
  output logic              renew_en_o,
  output logic              key_valid_o,
  output logic              seed_valid_o,
  input  logic [EscW-1:0]   escalate_i,
  output logic              kd_req_o,
  input  logic              kd_ack_i,
  input  logic [KeyW-1:0]   kd_key_i,
  input  logic [NonceW-1:0] kd_nonce_i,
  input  logic              kd_seed_valid_i,
  output logic [KeyW-1:0]   key_o,
  output logic [NonceW-1:0] nonce_o,
  output logic              wipe_o,
  output logic              busy_o
);
  logic renew_en_q, wipe_q, accept, esc, ack_evt, pending;

  assign esc    = (escalate_i != EscOff);
  assign accept = renew_we_i & renew_wdata_i & renew_en_q & ~pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      renew_en_q <= 1'b1;
      wipe_q     <= 1'b0;
    end else begin
      wipe_q <= accept;
      if (lock_we_i && !lock_wdata_i) renew_en_q <= 1'b0;
    end
  end

  kr_handshake i_hs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_kd_i (clk_kd_i),
    .rst_kd_ni(rst_kd_ni),
    .start_i  (accept),
    .ack_evt_o(ack_evt),
    .busy_o   (busy_o),
    .pending_o(pending),
    .kd_req_o (kd_req_o),
    .kd_ack_i (kd_ack_i)
  );

  kr_key_store #(.KeyW(KeyW), .NonceW(NonceW)) i_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .esc_i          (esc),
    .invalidate_i   (accept),
    .capture_i      (ack_evt),
    .kd_key_i       (kd_key_i),
    .kd_nonce_i     (kd_nonce_i),
    .kd_seed_valid_i(kd_seed_valid_i),
    .key_o          (key_o),
    .nonce_o        (nonce_o),
    .key_valid_o    (key_valid_o),
    .seed_valid_o   (seed_valid_o)
  );

  assign renew_en_o = renew_en_q;
  assign wipe_o     = wipe_q;

  // R2
  wipe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_o |-> busy_o && !key_valid_o);
  // R2
  wipe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_o |=> !wipe_o);
  // R6
  busy_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !key_valid_o);
  // R7
  no_rewipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && renew_we_i |=> !wipe_o);
  // R8
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !renew_en_o |=> !renew_en_o);
  // R8
  locked_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !renew_en_o && !busy_o |=> !wipe_o);
endmodule

// File: tb/test_key_renewal_ctrl.sv
module test_key_renewal_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int KD_PERIOD  = 14;
  localparam int KW = 128;
  localparam int NW = 64;
  localparam logic [3:0] OFF = 4'b0101;

  localparam int NV = 4;
  localparam logic [KW-1:0] VK [NV] = '{
    128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
    128'hffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff,
    128'h8000_0000_0000_0000_0000_0000_0000_0001,
    128'h5a5a_a5a5_3c3c_c3c3_0f0f_f0f0_1111_2222};
  localparam logic [NW-1:0] VN [NV] = '{
    64'hdead_beef_0000_0001, 64'h0000_0000_0000_0000,
    64'hffff_ffff_ffff_ffff, 64'h1234_5678_9abc_def0};
  localparam logic VS [NV] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam int VD [NV] = '{0, 3, 1, 7};

  logic clk = 0, clk_kd = 0, rst_n = 0, rst_kd_n = 0;
  logic renew_we = 0, renew_wdata = 0, lock_we = 0, lock_wdata = 0;
  logic [3:0] esc = OFF;
  logic kd_ack = 0, kd_seed = 0;
  logic [KW-1:0] kd_key = '0;
  logic [NW-1:0] kd_nonce = '0;
  logic renew_en, key_valid, seed_valid, kd_req, wipe, busy;
  logic [KW-1:0] key;
  logic [NW-1:0] nonce;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(KD_PERIOD/2) clk_kd = ~clk_kd;

  key_renewal_ctrl i_key_renewal_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .clk_kd_i(clk_kd), .rst_kd_ni(rst_kd_n),
    .renew_we_i(renew_we), .renew_wdata_i(renew_wdata),
    .lock_we_i(lock_we), .lock_wdata_i(lock_wdata),
    .renew_en_o(renew_en), .key_valid_o(key_valid), .seed_valid_o(seed_valid),
    .escalate_i(esc), .kd_req_o(kd_req), .kd_ack_i(kd_ack),
    .kd_key_i(kd_key), .kd_nonce_i(kd_nonce), .kd_seed_valid_i(kd_seed),
    .key_o(key), .nonce_o(nonce), .wipe_o(wipe), .busy_o(busy));

  task automatic chk(string req, logic [KW-1:0] act, logic [KW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic write_renew(logic d);
    @(negedge clk);
    renew_we = 1; renew_wdata = d;
    @(negedge clk);
    renew_we = 0; renew_wdata = 0;
  endtask

  // responder in the derivation domain; checks request shape (R3)
  task automatic respond(logic [KW-1:0] k, logic [NW-1:0] n, logic s, int dly);
    int guard = 0;
    @(negedge clk_kd);
    while (!kd_req && guard < 100) begin @(negedge clk_kd); guard++; end
    chk("R3 req rises", kd_req, 1);
    repeat (dly) @(negedge clk_kd);
    chk("R3 req held", kd_req, 1);
    kd_ack = 1; kd_key = k; kd_nonce = n; kd_seed = s;
    @(negedge clk_kd);
    kd_ack = 0;
    chk("R3 req drops", kd_req, 0);
  endtask

  task automatic wait_idle();
    int g = 0;
    @(negedge clk);
    while (busy && g < 200) begin @(negedge clk); g++; end
    chk("R6 busy clears", busy, 0);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 key", key, 0);
    chk("R1 nonce", {64'h0, nonce}, 0);
    chk("R1 flags", {key_valid, seed_valid, busy, wipe, kd_req}, 0);
    chk("R1 renew_en", renew_en, 1);
    rst_n = 1; rst_kd_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 key after release", key, 0);

    // R11
    write_renew(0);
    chk("R11 no busy", busy, 0);
    chk("R11 no wipe", wipe, 0);

    for (int i = 0; i < NV; i++) begin
      write_renew(1);
      chk("R2 busy", busy, 1);
      chk("R2 wipe", wipe, 1);
      chk("R2 valid low", key_valid, 0);
      @(negedge clk);
      chk("R2 wipe one cycle", wipe, 0);
      if (i == 1) begin
        write_renew(1); // R7
        chk("R7 no rewipe", wipe, 0);
        chk("R7 still busy", busy, 1);
      end
      respond(VK[i], VN[i], VS[i], VD[i]);
      wait_idle();
      chk("R4 key", key, VK[i]);
      chk("R4 nonce", {64'h0, nonce}, {64'h0, VN[i]});
      chk("R4 valid", key_valid, 1);
      chk("R5 seed", seed_valid, VS[i]);
    end

    // R9: escalation on a loaded key
    @(negedge clk);
    esc = 4'b0000;
    #1 chk("R9 key zero same cycle", key, 0);
    chk("R9 nonce zero", {64'h0, nonce}, 0);
    @(negedge clk);
    chk("R9 valid dropped", key_valid, 0);
    esc = 4'b1101;
    @(negedge clk);
    esc = OFF;
    @(negedge clk);
    chk("R9 key stays zero", key, 0);
    chk("R9 valid stays low", key_valid, 0);

    // R10: ack during escalation
    write_renew(1);
    esc = 4'b1111;
    respond(VK[0], VN[0], 1'b1, 2);
    wait_idle();
    chk("R10 key zero", key, 0);
    chk("R10 valid low", key_valid, 0);
    esc = OFF;
    @(negedge clk);
    chk("R10 key zero after release", key, 0);

    // fresh key then lock (R8)
    write_renew(1);
    respond(VK[3], VN[3], 1'b1, 0);
    wait_idle();
    chk("R4 key after escalation", key, VK[3]);
    @(negedge clk);
    lock_we = 1; lock_wdata = 0;
    @(negedge clk);
    lock_we = 1; lock_wdata = 1;
    @(negedge clk);
    lock_we = 0;
    chk("R8 renew_en cleared", renew_en, 0);
    write_renew(1);
    chk("R8 no busy", busy, 0);
    chk("R8 no wipe", wipe, 0);
    repeat (10) @(negedge clk);
    chk("R8 kd_req idle", kd_req, 0);
    chk("R8 key kept", key, VK[3]);
    chk("R8 valid kept", key_valid, 1);

    report();
  end
endmodule